// File: doc/BRIEF.md
# Retained Key Register Controller

This block keeps a small bank of secret key words whose contents outlive an ordinary reset. Software reaches it through a 32-bit register bus that moves one full word per access. The bank holds eight key words and one auxiliary word. The key words can only be written, and they always read as zero. Writes to them are accepted only after software has stored a fixed unlock value in the programming register.

A zeroize command wipes the bank and raises a flag. That flag falls again as soon as real key material is written. An on-demand integrity check runs a CRC-32C over the bank, one word per clock, and compares the result with a value that software supplies. The auxiliary word can be frozen by a lock that only a power-on reset releases. A build option makes the auxiliary word write-only instead. A single interrupt source reports bus accesses that hit no register, and a mask can hide it.

The block has two resets. `por_n` is power-on reset and clears everything. `rst_n` is the ordinary reset: it returns the control and status state to its defaults but leaves the key words, the auxiliary word, programming mode and the lock untouched.

Top module: `keyvault_ctrl`

## Requirements
- R1: After power-on reset the status register at offset 0x00 reads 0, the mask register at 0x3C reads 1 (masked) and `irq` is low.
- R2: Writing exactly 0x757BDF0D to offset 0x08 sets status bit 0 (programming mode); any other written value leaves it clear.
- R3: Programming mode stays set through an ordinary reset and is cleared only by power-on reset.
- R4: A write to a key word (offsets 0x10 to 0x2C, word i at 0x10+4i) while programming mode is clear leaves the stored word unchanged.
- R5: Reads of the key words and of the CRC register at 0x0C always return 0.
- R6: Writing 1 in bit 0 of offset 0x04 clears all key words, sets status bit 4 (zeroized) and also clears the auxiliary word only in the write-only build; offset 0x04 reads 0.
- R7: An admitted write of a nonzero value to a key word clears status bit 4; a zero value does not; a nonzero auxiliary-word write clears it only in the write-only build.
- R8: A write to 0x0C in programming mode starts a check that sets status bit 8 exactly 9 clock cycles later. At the same time it sets status bit 9 to whether the written value equals the CRC-32C (reflected polynomial 0x82F63B78, initial value 0, final inversion) of one zero word followed by key words 0 to 7. Outside programming mode such a write does nothing.
- R9: The auxiliary word at 0x30 is written only when programming mode is set and the lock is clear; it reads back its value, or 0 in the write-only build.
- R10: Writing 1 to bit 0 of 0x4C sets a lock that stays set through ordinary reset and writes of 0, clears on power-on reset, and never sets in the write-only build.
- R11: An ordinary reset leaves the key words and the auxiliary word unchanged.
- R12: `irq` equals the pending bit (0x38 bit 0) AND NOT the mask bit (0x3C bit 0). Writing 1 to 0x40 bit 0 clears the mask, writing 1 to 0x44 bit 0 sets it, and writing 1 to 0x38 bit 0 clears the pending bit.
- R13: When 0x34 bit 0 is set, an access to an offset that is unaligned, equals 0x48 or lies above 0x4C raises `rsp_err` in the same cycle and sets the pending bit; when it is clear no error is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | Ordinary reset, active low, synchronous |
| req_valid | input | 1 | Bus access present this cycle |
| req_write | input | 1 | Access is a write |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid in the access cycle |
| rsp_err | output | 1 | Slave error for the current access |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that there is at most one access per cycle, and that while a check is running nobody writes the key bank, zeroizes it or starts a second check. The engine reads the live bank word by word, so such traffic would change the result without breaking any rule of the logic. The stimulus keeps to this by waiting out the full nine cycles after each CRC write before the next access, and by driving one access per cycle through a single task. Both the readable and the write-only builds receive the same traffic, so each difference between them is seen side by side.

// File: rtl/keyvault_pkg.sv
package keyvault_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t CRC_POLY = 32'h82F63B78;

    // byte offsets of the register window
    localparam int OFF_STATUS = 'h00;
    localparam int OFF_CTRL   = 'h04;
    localparam int OFF_PGM    = 'h08;
    localparam int OFF_CRC    = 'h0C;
    localparam int OFF_KEY0   = 'h10;
    localparam int OFF_SLVERR = 'h34;
    localparam int OFF_ISR    = 'h38;
    localparam int OFF_IMR    = 'h3C;
    localparam int OFF_IER    = 'h40;
    localparam int OFF_IDR    = 'h44;
    localparam int OFF_LOCK   = 'h4C;

    // status bit positions
    localparam int ST_PGM  = 0;
    localparam int ST_ZERO = 4;
    localparam int ST_DONE = 8;
    localparam int ST_PASS = 9;

    // fold one 32-bit word into a reflected CRC-32C remainder
    function automatic word_t crc_step(word_t c, word_t w);
        word_t r;
        r = c ^ w;
        for (int b = 0; b < WORD_W; b++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/keyvault_crc.sv
module keyvault_crc
    import keyvault_pkg::*;
#(
    parameter int NKEY = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [NKEY-1:0][WORD_W-1:0] keys_i,
    output logic                        fin_o,
    output word_t                       sum_o
);
    localparam int IDX_W = $clog2(NKEY + 1);
    localparam int SEL_W = (NKEY > 1) ? $clog2(NKEY) : 1;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        word_t            crc;
    } eng_t;

    eng_t  eng_d, eng_q;
    word_t cur_word;
    logic [SEL_W-1:0] sel;
    logic  last;

    always_comb begin
        // index 0 is the leading all-zero word
        sel      = SEL_W'(eng_q.idx - IDX_W'(1));
        cur_word = (eng_q.idx == '0) ? '0 : keys_i[sel];
        last     = eng_q.busy && (eng_q.idx == IDX_W'(NKEY));
        eng_d    = eng_q;
        if (start_i) begin
            eng_d.busy = 1'b1;
            eng_d.idx  = '0;
            eng_d.crc  = '0;
        end else if (eng_q.busy) begin
            eng_d.crc = crc_step(eng_q.crc, cur_word);
            if (last) begin
                eng_d.busy = 1'b0;
            end else begin
                eng_d.idx = eng_q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign fin_o = last;
    assign sum_o = ~crc_step(eng_q.crc, cur_word);

    AST_CRC_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !fin_o); // R8

    AST_CRC_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (eng_q.busy && !fin_o)); // R8
endmodule

// File: rtl/keyvault_irq.sv
module keyvault_irq #(
    parameter int IRQ_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_i,
    input  logic [IRQ_W-1:0] clr_i,
    input  logic [IRQ_W-1:0] unmask_i,
    input  logic [IRQ_W-1:0] mask_i,
    output logic [IRQ_W-1:0] isr_o,
    output logic [IRQ_W-1:0] imr_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [IRQ_W-1:0] isr;
        logic [IRQ_W-1:0] imr;
    } irq_t;

    irq_t irq_d, irq_q;

    always_comb begin
        irq_d     = irq_q;
        irq_d.isr = (irq_q.isr & ~clr_i) | set_i;
        irq_d.imr = (irq_q.imr & ~unmask_i) | mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q.isr <= '0;
            irq_q.imr <= '1;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign isr_o = irq_q.isr;
    assign imr_o = irq_q.imr;
    assign irq_o = |(irq_q.isr & ~irq_q.imr);

    AST_UNMASK_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        ((unmask_i != '0) && (mask_i == '0)) |=> ((imr_o & $past(unmask_i)) == '0)); // R12

    AST_SET_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((isr_o & $past(set_i)) == $past(set_i))); // R13
endmodule

// File: rtl/keyvault_ctrl.sv
module keyvault_ctrl
    import keyvault_pkg::*;
#(
    parameter int    ADDR_W  = 8,
    parameter int    NKEY    = 8,
    parameter int    IRQ_W   = 1,
    parameter bit    AUX_WO  = 1'b0,
    parameter word_t PGM_KEY = 32'h757BDF0D
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              irq
);
    localparam int OFF_AUX = OFF_KEY0 + 4 * NKEY;
    localparam int KIDX_W  = (NKEY > 1) ? $clog2(NKEY) : 1;

    // state that only power-on reset touches
    typedef struct packed {
        logic [NKEY-1:0][WORD_W-1:0] keys;
        word_t                       aux;
        logic                        pgm;
        logic                        lock;
    } ret_t;

    // state returned to defaults by either reset
    typedef struct packed {
        logic  zeroized;
        logic  done;
        logic  pass;
        logic  slv_en;
        word_t ref_sum;
    } ctl_t;

    ret_t ret_d, ret_q;
    ctl_t ctl_d, ctl_q;

    logic sys_rst_n;
    logic wr, aligned, mapped;
    logic hit_status, hit_ctrl, hit_pgm, hit_crc, hit_aux, hit_slverr;
    logic hit_isr, hit_imr, hit_ier, hit_idr, hit_lock, key_hit;
    logic [KIDX_W-1:0] key_idx;
    logic zap, crc_go, crc_fin;
    word_t crc_sum;
    logic [IRQ_W-1:0] isr, imr, isr_clr, ier_w, idr_w;

    assign sys_rst_n = por_n & rst_n;
    assign wr        = req_valid && req_write;
    assign aligned   = (req_addr[1:0] == 2'b00);

    assign hit_status = (req_addr == ADDR_W'(OFF_STATUS));
    assign hit_ctrl   = (req_addr == ADDR_W'(OFF_CTRL));
    assign hit_pgm    = (req_addr == ADDR_W'(OFF_PGM));
    assign hit_crc    = (req_addr == ADDR_W'(OFF_CRC));
    assign hit_aux    = (req_addr == ADDR_W'(OFF_AUX));
    assign hit_slverr = (req_addr == ADDR_W'(OFF_SLVERR));
    assign hit_isr    = (req_addr == ADDR_W'(OFF_ISR));
    assign hit_imr    = (req_addr == ADDR_W'(OFF_IMR));
    assign hit_ier    = (req_addr == ADDR_W'(OFF_IER));
    assign hit_idr    = (req_addr == ADDR_W'(OFF_IDR));
    assign hit_lock   = (req_addr == ADDR_W'(OFF_LOCK));
    assign key_hit    = aligned && (req_addr >= ADDR_W'(OFF_KEY0))
                                && (req_addr <  ADDR_W'(OFF_AUX));
    assign key_idx    = KIDX_W'((req_addr - ADDR_W'(OFF_KEY0)) >> 2);

    assign mapped = hit_status | hit_ctrl | hit_pgm | hit_crc | key_hit | hit_aux
                  | hit_slverr | hit_isr | hit_imr | hit_ier | hit_idr | hit_lock;

    assign rsp_err = req_valid && !mapped && ctl_q.slv_en;
    assign zap     = wr && hit_ctrl && req_wdata[0];
    assign crc_go  = wr && hit_crc && ret_q.pgm;
    assign isr_clr = (wr && hit_isr) ? req_wdata[IRQ_W-1:0] : '0;
    assign ier_w   = (wr && hit_ier) ? req_wdata[IRQ_W-1:0] : '0;
    assign idr_w   = (wr && hit_idr) ? req_wdata[IRQ_W-1:0] : '0;

    always_comb begin
        ret_d = ret_q;
        ctl_d = ctl_q;

        if (wr && key_hit && ret_q.pgm) begin
            ret_d.keys[key_idx] = req_wdata;
            if (req_wdata != '0) ctl_d.zeroized = 1'b0;
        end
        if (wr && hit_aux && ret_q.pgm && !ret_q.lock) begin
            ret_d.aux = req_wdata;
            if (AUX_WO && (req_wdata != '0)) ctl_d.zeroized = 1'b0;
        end
        if (wr && hit_pgm && (req_wdata == PGM_KEY)) begin
            ret_d.pgm = 1'b1;
        end
        if (wr && hit_lock && req_wdata[0] && !AUX_WO) begin
            ret_d.lock = 1'b1;
        end
        if (wr && hit_slverr) begin
            ctl_d.slv_en = req_wdata[0];
        end
        if (zap) begin
            ret_d.keys = '0;
            if (AUX_WO) ret_d.aux = '0;
            ctl_d.zeroized = 1'b1;
        end
        if (crc_go) begin
            ctl_d.done    = 1'b0;
            ctl_d.pass    = 1'b0;
            ctl_d.ref_sum = req_wdata;
        end
        if (crc_fin) begin
            ctl_d.done = 1'b1;
            ctl_d.pass = (crc_sum == ctl_q.ref_sum);
        end
    end

    always_comb begin
        rsp_rdata = '0;
        if (hit_status) begin
            rsp_rdata[ST_PGM]  = ret_q.pgm;
            rsp_rdata[ST_ZERO] = ctl_q.zeroized;
            rsp_rdata[ST_DONE] = ctl_q.done;
            rsp_rdata[ST_PASS] = ctl_q.pass;
        end
        if (hit_aux && !AUX_WO) rsp_rdata = ret_q.aux;
        if (hit_slverr)         rsp_rdata[0] = ctl_q.slv_en;
        if (hit_isr)            rsp_rdata[IRQ_W-1:0] = isr;
        if (hit_imr)            rsp_rdata[IRQ_W-1:0] = imr;
        if (hit_lock)           rsp_rdata[0] = ret_q.lock;
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= ret_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!sys_rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    keyvault_crc #(.NKEY(NKEY)) u_crc (
        .clk     (clk),
        .rst_n   (sys_rst_n),
        .start_i (crc_go),
        .keys_i  (ret_q.keys),
        .fin_o   (crc_fin),
        .sum_o   (crc_sum)
    );

    keyvault_irq #(.IRQ_W(IRQ_W)) u_irq (
        .clk      (clk),
        .rst_n    (sys_rst_n),
        .set_i    (IRQ_W'(rsp_err)),
        .clr_i    (isr_clr),
        .unmask_i (ier_w),
        .mask_i   (idr_w),
        .isr_o    (isr),
        .imr_o    (imr),
        .irq_o    (irq)
    );

    AST_PGM_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        ret_q.pgm |=> ret_q.pgm); // R3

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        ret_q.lock |=> ret_q.lock); // R10

    AST_KEYS_GATED: assert property (@(posedge clk) disable iff (!por_n)
        (!ret_q.pgm && !zap) |=> $stable(ret_q.keys)); // R4

    AST_DONE_FROM_ENGINE: assert property (@(posedge clk) disable iff (!sys_rst_n)
        $rose(ctl_q.done) |-> $past(crc_fin)); // R8

    AST_ZAP_FLAGS: assert property (@(posedge clk) disable iff (!sys_rst_n)
        zap |=> (ctl_q.zeroized && (ret_q.keys == '0))); // R6

    AST_ERR_PENDS: assert property (@(posedge clk) disable iff (!sys_rst_n)
        rsp_err |=> isr[0]); // R13
endmodule

// File: tb/keyvault_ctrl_test.sv
module keyvault_ctrl_test;
    logic        clk = 1'b0;
    logic        por_n, rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata;
    logic [31:0] rd_a, rd_b;
    logic        err_a, err_b, irq_a, irq_b;

    logic [31:0] sa_rd, sb_rd;
    logic        sa_err, sb_err, sa_irq, sb_irq;
    logic [31:0] km [8];
    int          n_vec = 0;
    int          n_bad = 0;
    bit          finished = 0;

    localparam logic [31:0] MAGIC = 32'h757BDF0D;

    always #4 clk = ~clk;

    keyvault_ctrl #(.AUX_WO(1'b0)) uut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rd_a), .rsp_err(err_a), .irq(irq_a)
    );

    keyvault_ctrl #(.AUX_WO(1'b1)) uut_wo (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rd_b), .rsp_err(err_b), .irq(irq_b)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic access(input logic w, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #2;
        sa_rd = rd_a; sa_err = err_a; sa_irq = irq_a;
        sb_rd = rd_b; sb_err = err_b; sb_irq = irq_b;
        @(posedge clk);
        #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        access(1'b1, a, d);
    endtask

    task automatic rd(input logic [7:0] a);
        access(1'b0, a, 32'h0);
    endtask

    function automatic logic [31:0] model_crc();
        logic [31:0] c;
        c = 32'h0;
        for (int i = 0; i <= 8; i++) begin
            logic [31:0] w;
            w = (i == 0) ? 32'h0 : km[i-1];
            c = c ^ w;
            for (int b = 0; b < 32; b++) begin
                c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
            end
        end
        return ~c;
    endfunction

    // start a check, confirm bit 8 is still low after 8 cycles and high after 9
    task automatic run_crc(input string tag, input logic [31:0] val, input logic pass);
        wr(8'h0C, val);
        repeat (8) @(posedge clk);
        rd(8'h00);
        chk({tag, " done not before cycle 9"}, {31'h0, sa_rd[8]}, 32'h0);
        chk({tag, " done not before cycle 9 wo"}, {31'h0, sb_rd[8]}, 32'h0);
        rd(8'h00);
        chk({tag, " done+pass"}, {30'h0, sa_rd[9], sa_rd[8]}, {30'h0, pass, 1'b1});
        chk({tag, " done+pass wo"}, {30'h0, sb_rd[9], sb_rd[8]}, {30'h0, pass, 1'b1});
    endtask

    function automatic logic is_mapped(input logic [7:0] a);
        return (a[1:0] == 2'b00) && ((a <= 8'h44) || (a == 8'h4C));
    endfunction

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
        por_n = 0; rst_n = 0;
        for (int i = 0; i < 8; i++) km[i] = 32'h0;
        repeat (3) @(posedge clk);
        #1; por_n = 1; rst_n = 1;

        // R1 reset state
        rd(8'h00);
        chk("R1 status", sa_rd, 32'h0);
        chk("R1 status wo", sb_rd, 32'h0);
        rd(8'h3C);
        chk("R1 mask", sa_rd, 32'h1);
        chk("R1 irq", {31'h0, sa_irq}, 32'h0);

        // R4 key write before programming mode is dropped
        wr(8'h10, 32'h11111111);
        // R8 check request outside programming mode does nothing
        wr(8'h0C, 32'h0);
        repeat (12) @(posedge clk);
        rd(8'h00);
        chk("R8 no check without pgm", {31'h0, sa_rd[8]}, 32'h0);
        // R9 aux write without programming mode is dropped
        wr(8'h30, 32'h55);
        rd(8'h30);
        chk("R9 aux gated by pgm", sa_rd, 32'h0);

        // R2 every single-bit corruption of the unlock value is rejected
        for (int b = 0; b < 32; b++) begin
            wr(8'h08, MAGIC ^ (32'h1 << b));
            rd(8'h00);
            chk("R2 near-miss unlock", {31'h0, sa_rd[0]}, 32'h0);
            chk("R2 near-miss unlock wo", {31'h0, sb_rd[0]}, 32'h0);
        end
        wr(8'h08, MAGIC);
        rd(8'h00);
        chk("R2 unlock", {31'h0, sa_rd[0]}, 32'h1);
        chk("R2 unlock wo", {31'h0, sb_rd[0]}, 32'h1);

        // R4 bank must still be all zero: check passes with the zero-bank CRC
        run_crc("R4", model_crc(), 1'b1);

        // R5 load a pattern, then read every key word and the CRC register
        for (int i = 0; i < 8; i++) begin
            km[i] = (32'h9E3779B9 * (i + 1)) ^ 32'h0F0F0000;
            wr(8'(8'h10 + 4 * i), km[i]);
        end
        for (int i = 0; i < 8; i++) begin
            rd(8'(8'h10 + 4 * i));
            chk("R5 key reads zero", sa_rd, 32'h0);
            chk("R5 key reads zero wo", sb_rd, 32'h0);
        end
        rd(8'h0C);
        chk("R5 crc reg reads zero", sa_rd, 32'h0);

        // R8 wrong and right reference values
        run_crc("R8 mismatch", model_crc() ^ 32'h1, 1'b0);
        run_crc("R8 match", model_crc(), 1'b1);

        // R9 aux word readback vs write-only build
        wr(8'h30, 32'hA5A50009);
        rd(8'h30);
        chk("R9 aux readback", sa_rd, 32'hA5A50009);
        chk("R9 aux write-only", sb_rd, 32'h0);

        // R6 zeroize
        wr(8'h04, 32'h1);
        rd(8'h00);
        chk("R6 zeroized flag", {31'h0, sa_rd[4]}, 32'h1);
        chk("R6 zeroized flag wo", {31'h0, sb_rd[4]}, 32'h1);
        rd(8'h04);
        chk("R6 ctrl self-clears", sa_rd, 32'h0);
        for (int i = 0; i < 8; i++) km[i] = 32'h0;
        run_crc("R6 bank cleared", model_crc(), 1'b1);
        rd(8'h30);
        chk("R6 readable aux kept", sa_rd, 32'hA5A50009);

        // R7 zeroized flag handling
        wr(8'h1C, 32'h0);
        rd(8'h00);
        chk("R7 zero write keeps flag", {31'h0, sa_rd[4]}, 32'h1);
        wr(8'h30, 32'h77);
        rd(8'h00);
        chk("R7 aux write readable build", {31'h0, sa_rd[4]}, 32'h1);
        chk("R7 aux write write-only build", {31'h0, sb_rd[4]}, 32'h0);
        km[1] = 32'h00001234;
        wr(8'h14, km[1]);
        rd(8'h00);
        chk("R7 key write clears flag", {31'h0, sa_rd[4]}, 32'h0);

        // R10 lock, R9 lock blocks aux writes
        wr(8'h4C, 32'h1);
        rd(8'h4C);
        chk("R10 lock set", sa_rd, 32'h1);
        chk("R10 lock never in wo", sb_rd, 32'h0);
        wr(8'h30, 32'hDEAD);
        rd(8'h30);
        chk("R9 locked aux unchanged", sa_rd, 32'h77);
        wr(8'h4C, 32'h0);
        rd(8'h4C);
        chk("R10 lock sticky", sa_rd, 32'h1);

        // R11 ordinary reset keeps retained state
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        rd(8'h00);
        chk("R3 pgm survives reset", {31'h0, sa_rd[0]}, 32'h1);
        chk("R11 status flags reset", {22'h0, sa_rd[9:8], 3'h0, sa_rd[4], 4'h0}, 32'h0);
        rd(8'h4C);
        chk("R10 lock survives reset", sa_rd, 32'h1);
        rd(8'h30);
        chk("R11 aux survives reset", sa_rd, 32'h77);
        run_crc("R11 keys survive reset", model_crc(), 1'b1);

        // R13 slave error disabled, then enabled sweep
        rd(8'h48);
        chk("R13 no error when disabled", {31'h0, sa_err}, 32'h0);
        wr(8'h34, 32'h1);
        rd(8'h34);
        chk("R13 enable readback", sa_rd, 32'h1);
        for (int a = 0; a < 128; a++) begin
            rd(8'(a));
            chk("R13 error sweep", {31'h0, sa_err}, {31'h0, ~is_mapped(8'(a))});
            chk("R13 error sweep wo", {31'h0, sb_err}, {31'h0, ~is_mapped(8'(a))});
        end

        // R12 interrupt masking
        rd(8'h38);
        chk("R12 pending set", sa_rd, 32'h1);
        chk("R12 masked irq low", {31'h0, sa_irq}, 32'h0);
        wr(8'h40, 32'h1);
        rd(8'h3C);
        chk("R12 unmask clears mask", sa_rd, 32'h0);
        chk("R12 irq high", {31'h0, sa_irq}, 32'h1);
        wr(8'h44, 32'h1);
        rd(8'h3C);
        chk("R12 mask set", sa_rd, 32'h1);
        chk("R12 irq masked again", {31'h0, sa_irq}, 32'h0);
        wr(8'h40, 32'h1);
        wr(8'h38, 32'h1);
        rd(8'h38);
        chk("R12 pending cleared", sa_rd, 32'h0);
        chk("R12 irq after clear", {31'h0, sa_irq}, 32'h0);

        // R3 / R10 power-on reset clears programming mode and lock
        @(negedge clk); por_n = 0;
        repeat (2) @(negedge clk);
        por_n = 1;
        rd(8'h00);
        chk("R3 pgm cleared by por", sa_rd, 32'h0);
        rd(8'h4C);
        chk("R10 lock cleared by por", sa_rd, 32'h0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule